// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM. Its reads flow through: the address and controls are registered on the rising clock edge, and the addressed word reaches the data output in the cycle after that edge, with no output register. Every clock cycle is classed as one of five kinds. A deselect ends any burst. A begin loads an external address. A continue steps to the next address of a four-word burst. A suspend holds the current address. A hold applies while the block is deselected and no strobe is seen.

Two address strobes start bursts. The host strobe is qualified by the first active-low enable only, and the burst it starts always opens with a read. The controller strobe is qualified by all three enables and may open with a write. Writes are masked by byte lane. A global write writes every lane. A lane-write master enable, together with per-lane selects, writes only the chosen lanes. The burst order is either linear or interleaved. An asynchronous output enable gates the read data. A sleep input freezes the block without losing the array contents or the burst position. Separate data-in, data-out and valid ports take the place of a bidirectional pin.

Top module: `fts_burst_sram`

## Requirements
- R1: The block counts as selected only when `en_lo_a_n`=0, `en_hi`=1 and `en_lo_b_n`=0. A qualified strobe seen while any other enable combination is present deselects the block, and `rvalid` is 0 afterwards.
- R2: Once deselected, the block writes nothing and keeps `rvalid` at 0 through any number of cycles with both strobes high, until a new begin cycle occurs.
- R3: A begin cycle loads `addr` as the burst base and resets the burst count to 0. It is started by `host_start_n`=0 while `en_lo_a_n`=0, or by `ctrl_start_n`=0. While `en_lo_a_n`=1 the host strobe is ignored, and the cycle is decoded as if that strobe were high.
- R4: A burst begun by the host strobe always starts with a read, whatever the write inputs are. When both strobes are low and the host strobe is qualified, the host strobe decides the cycle.
- R5: When both strobes are high during an active burst, `step_n`=0 advances the burst count by one (modulo 4), and `step_n`=1 keeps the same address. Write inputs apply in both cases.
- R6: The word address is the base address with its two low bits replaced. With `wrap_linear`=1 they become (base[1:0] + count) mod 4. With `wrap_linear`=0 they become base[1:0] XOR count. The upper bits never change within a burst.
- R7: `all_wr_n`=0 writes all lanes. Otherwise, `lane_wr_en_n`=0 writes every lane g for which `lane_sel_n[g]`=0, using data bits g*LANE_W+:LANE_W. Any other combination is a read. Lanes not selected keep their contents.
- R8: After a read cycle's edge, `rdata` shows the word at that cycle's address during the following clock period. `rvalid` is 1 only during an active read cycle. It is 0 during write and deselected cycles, and `rdata` is 0 whenever `rvalid` is 0.
- R9: `read_oe_n`=1 forces `rvalid` to 0 at once, with no clock edge needed. Returning it to 0 restores the read data at once.
- R10: While `nap`=1, `rvalid` is 0 at once and clock edges change nothing, so the array and the burst state are kept. The first edge after `nap` returns to 0 is ignored as well.
- R11: While `rst_n`=0 the block is deselected, with the burst count at 0 and `rvalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nap | input | 1 | Sleep: freezes state, floats read data |
| wrap_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | External word address |
| host_start_n | input | 1 | Host burst strobe, active low, read-first |
| ctrl_start_n | input | 1 | Controller burst strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| en_lo_a_n | input | 1 | First active-low enable (also qualifies host strobe) |
| en_hi | input | 1 | Active-high enable |
| en_lo_b_n | input | 1 | Second active-low enable |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_en_n | input | 1 | Lane-write master enable |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| read_oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, 0 when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The hardest situation to reach from the ports is a change of sleep state or chip enables in the middle of a burst. That requires a burst that is already running, and then a write or advance cycle that must be ignored or must stay dead. The stimulus draws sleep, enable combinations, strobes and write enables independently on every cycle, so these collisions occur thousands of times. Directed sequences add three cases: a write attempted during sleep and during the recovery edge, continue-writes after a deselect, and a host strobe with all write enables low. Each is followed by reads of the same words.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_HOLD  = 3'd0,
        CYC_DESEL = 3'd1,
        CYC_BEGIN = 3'd2,
        CYC_CONT  = 3'd3,
        CYC_SUSP  = 3'd4
    } cyc_e;

endpackage

// File: rtl/fts_cycle_decode.sv
module fts_cycle_decode
    import fts_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             en_lo_a_n,
    input  logic             en_hi,
    input  logic             en_lo_b_n,
    input  logic             host_start_n,
    input  logic             ctrl_start_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             burst_live,
    output cyc_e             kind,
    output logic [LANES-1:0] lane_we
);

    logic             selected;
    logic             host_live;
    logic [LANES-1:0] wmask;

    always_comb begin
        selected  = !en_lo_a_n && en_hi && !en_lo_b_n;
        host_live = !host_start_n && !en_lo_a_n;
        if (!all_wr_n) begin
            wmask = '1;
        end else if (!lane_wr_en_n) begin
            wmask = ~lane_sel_n;
        end else begin
            wmask = '0;
        end

        kind    = CYC_HOLD;
        lane_we = '0;
        if (host_live) begin
            kind = selected ? CYC_BEGIN : CYC_DESEL;
        end else if (!ctrl_start_n) begin
            if (selected) begin
                kind    = CYC_BEGIN;
                lane_we = wmask;
            end else begin
                kind = CYC_DESEL;
            end
        end else if (burst_live) begin
            kind    = step_n ? CYC_SUSP : CYC_CONT;
            lane_we = wmask;
        end
    end

endmodule

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
    import fts_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic [AW-1:0]      base,
    input  logic [BURST_W-1:0] cnt,
    input  logic               wrap_linear,
    output logic [AW-1:0]      word_addr
);

    logic [BURST_W-1:0] low;

    always_comb begin
        if (wrap_linear) begin
            low = base[BURST_W-1:0] + cnt;
        end else begin
            low = base[BURST_W-1:0] ^ cnt;
        end
        word_addr = {base[AW-1:BURST_W], low};
    end

endmodule

// File: rtl/fts_store.sv
module fts_store #(
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic [LANES-1:0] lane_we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                bank[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
    import fts_pkg::*;
#(
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nap,
    input  logic             wrap_linear,
    input  logic [AW-1:0]    addr,
    input  logic             host_start_n,
    input  logic             ctrl_start_n,
    input  logic             step_n,
    input  logic             en_lo_a_n,
    input  logic             en_hi,
    input  logic             en_lo_b_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             read_oe_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);

    typedef struct packed {
        logic               active;
        logic               wr;
        logic               nap_seen;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] cnt;
    } state_t;

    state_t             st_d, st_q;
    cyc_e               kind;
    logic [LANES-1:0]   lane_we;
    logic [LANES-1:0]   lane_commit;
    logic [AW-1:0]      cur_addr;
    logic [AW-1:0]      next_addr;
    logic [DW-1:0]      array_word;

    // Plain copies of the state for the bound checker.
    logic               live_q;
    logic               wr_q;
    logic               nap_q;
    logic [BURST_W-1:0] cnt_q;
    logic [AW-1:0]      base_q;

    fts_cycle_decode #(.LANES(LANES)) decode_i (
        .en_lo_a_n    (en_lo_a_n),
        .en_hi        (en_hi),
        .en_lo_b_n    (en_lo_b_n),
        .host_start_n (host_start_n),
        .ctrl_start_n (ctrl_start_n),
        .step_n       (step_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .burst_live   (st_q.active),
        .kind         (kind),
        .lane_we      (lane_we)
    );

    fts_burst_addr #(.AW(AW)) cur_gen_i (
        .base        (st_q.base),
        .cnt         (st_q.cnt),
        .wrap_linear (wrap_linear),
        .word_addr   (cur_addr)
    );

    fts_burst_addr #(.AW(AW)) next_gen_i (
        .base        (st_d.base),
        .cnt         (st_d.cnt),
        .wrap_linear (wrap_linear),
        .word_addr   (next_addr)
    );

    fts_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) store_i (
        .clk     (clk),
        .lane_we (lane_commit),
        .waddr   (next_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (array_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.nap_seen = nap;
        lane_commit   = '0;
        if (!(nap || st_q.nap_seen)) begin
            unique case (kind)
                CYC_BEGIN: begin
                    st_d.active = 1'b1;
                    st_d.base   = addr;
                    st_d.cnt    = '0;
                    st_d.wr     = |lane_we;
                    lane_commit = lane_we;
                end
                CYC_DESEL: begin
                    st_d.active = 1'b0;
                    st_d.wr     = 1'b0;
                end
                CYC_CONT: begin
                    st_d.cnt    = st_q.cnt + 1'b1;
                    st_d.wr     = |lane_we;
                    lane_commit = lane_we;
                end
                CYC_SUSP: begin
                    st_d.wr     = |lane_we;
                    lane_commit = lane_we;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.active && !st_q.wr && !read_oe_n && !nap;
    assign rdata  = rvalid ? array_word : '0;

    assign live_q = st_q.active;
    assign wr_q   = st_q.wr;
    assign nap_q  = st_q.nap_seen;
    assign cnt_q  = st_q.cnt;
    assign base_q = st_q.base;

endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nap,
    input logic          host_start_n,
    input logic          ctrl_start_n,
    input logic          step_n,
    input logic          en_lo_a_n,
    input logic          en_hi,
    input logic          en_lo_b_n,
    input logic          read_oe_n,
    input logic          rvalid,
    input logic          live_q,
    input logic          wr_q,
    input logic          nap_q,
    input logic [1:0]    cnt_q,
    input logic [AW-1:0] base_q
);

    AST_NAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        nap |=> ($stable(live_q) && $stable(cnt_q) && $stable(base_q))); // R10

    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_q && host_start_n && ctrl_start_n) |=> !live_q); // R2

    AST_HOST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && !nap_q && !host_start_n && !en_lo_a_n && en_hi && !en_lo_b_n)
        |=> (live_q && !wr_q && cnt_q == 2'd0)); // R4

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && !nap_q && live_q && host_start_n && ctrl_start_n && step_n)
        |=> ($stable(cnt_q) && $stable(base_q))); // R5

    AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && !nap_q && live_q && host_start_n && ctrl_start_n && !step_n)
        |=> (cnt_q == $past(cnt_q) + 2'd1)); // R5

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        read_oe_n |-> !rvalid); // R9

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q || !live_q) |-> !rvalid); // R8

endmodule

bind fts_burst_sram fts_burst_sram_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .nap          (nap),
    .host_start_n (host_start_n),
    .ctrl_start_n (ctrl_start_n),
    .step_n       (step_n),
    .en_lo_a_n    (en_lo_a_n),
    .en_hi        (en_hi),
    .en_lo_b_n    (en_lo_b_n),
    .read_oe_n    (read_oe_n),
    .rvalid       (rvalid),
    .live_q       (live_q),
    .wr_q         (wr_q),
    .nap_q        (nap_q),
    .cnt_q        (cnt_q),
    .base_q       (base_q)
);

// File: tb/fts_burst_sram_tb_top.sv
`timescale 1ns/1ps
module fts_burst_sram_tb_top;

    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int LANE_W = 8;
    localparam int DW = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nap = 1'b0, wrap_linear = 1'b1;
    logic [AW-1:0] addr = '0;
    logic host_start_n = 1'b1, ctrl_start_n = 1'b1, step_n = 1'b1;
    logic en_lo_a_n = 1'b0, en_hi = 1'b1, en_lo_b_n = 1'b0;
    logic all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [LANES-1:0] lane_sel_n = '1;
    logic read_oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid;

    always #10 clk = ~clk;

    fts_burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .nap(nap), .wrap_linear(wrap_linear), .addr(addr),
        .host_start_n(host_start_n), .ctrl_start_n(ctrl_start_n), .step_n(step_n),
        .en_lo_a_n(en_lo_a_n), .en_hi(en_hi), .en_lo_b_n(en_lo_b_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .read_oe_n(read_oe_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic m_active = 1'b0, m_wr = 1'b0, m_napq = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;

    function automatic logic [AW-1:0] slot(logic [AW-1:0] b, logic [1:0] c, logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [LANES-1:0] wmask_now();
        if (!all_wr_n) return '1;
        if (!lane_wr_en_n) return ~lane_sel_n;
        return '0;
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic put(logic [AW-1:0] a, logic [DW-1:0] d, logic [LANES-1:0] wm);
        for (int g = 0; g < LANES; g++)
            if (wm[g]) ref_mem[a][g*LANE_W +: LANE_W] = d[g*LANE_W +: LANE_W];
    endtask

    task automatic model_edge();
        logic sel, hlive;
        logic [LANES-1:0] wm;
        sel = !en_lo_a_n && en_hi && !en_lo_b_n;
        hlive = !host_start_n && !en_lo_a_n;
        wm = wmask_now();
        if (!nap && !m_napq) begin
            if (hlive) begin
                if (sel) begin m_active = 1; m_base = addr; m_cnt = 0; m_wr = 0; end
                else begin m_active = 0; m_wr = 0; end
            end else if (!ctrl_start_n) begin
                if (sel) begin
                    m_active = 1; m_base = addr; m_cnt = 0; m_wr = |wm;
                    put(slot(m_base, m_cnt, wrap_linear), wdata, wm);
                end else begin m_active = 0; m_wr = 0; end
            end else if (m_active) begin
                if (!step_n) m_cnt = m_cnt + 2'd1;
                m_wr = |wm;
                put(slot(m_base, m_cnt, wrap_linear), wdata, wm);
            end
        end
        m_napq = nap;
    endtask

    // Called just after a falling edge with the inputs already applied.
    task automatic run(string tag);
        logic ev;
        logic [DW-1:0] ed;
        #1;
        ev = m_active && !m_wr && !read_oe_n && !nap;
        ed = ev ? ref_mem[slot(m_base, m_cnt, wrap_linear)] : '0;
        check(tag, "rvalid", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, ev});
        check(tag, "rdata", rdata, ed);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        host_start_n = 1; ctrl_start_n = 1; step_n = 1;
        en_lo_a_n = 0; en_hi = 1; en_lo_b_n = 0;
        all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = '1;
        read_oe_n = 0; nap = 0;
    endtask

    task automatic begin_ctrl(logic [AW-1:0] a, logic wr_all, string tag);
        idle(); ctrl_start_n = 0; addr = a; all_wr_n = !wr_all;
        wdata = $urandom; run(tag);
    endtask

    task automatic step(logic adv, logic wr_all, string tag);
        idle(); step_n = !adv; all_wr_n = !wr_all; wdata = $urandom; run(tag);
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        idle();
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "rvalid in reset", {{(DW-1){1'b0}}, rvalid}, '0);
        check("R11", "rdata in reset", rdata, '0);
        rst_n = 1;
        @(negedge clk);

        // Preload whole array with write bursts (R7 global write, R5 continue)
        for (int b = 0; b < DEPTH / 4; b++) begin
            begin_ctrl(AW'(b * 4), 1'b1, "R7");
            for (int k = 0; k < 3; k++) step(1'b1, 1'b1, "R5");
        end

        // R6 linear order from unaligned base, then interleaved
        wrap_linear = 1;
        begin_ctrl(6'h09, 1'b0, "R6");
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, "R6");
        wrap_linear = 0;
        begin_ctrl(6'h0E, 1'b0, "R6");
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, "R6");
        wrap_linear = 1;

        // R5 suspend keeps address
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, "R5");

        // R7 lane-masked write then read back
        idle(); ctrl_start_n = 0; addr = 6'h20; lane_wr_en_n = 0; lane_sel_n = 4'b1010;
        wdata = 32'hA1B2C3D4; run("R7");
        idle(); lane_wr_en_n = 0; lane_sel_n = 4'b1111; run("R7");
        step(1'b0, 1'b0, "R7");

        // R4 host strobe with write enables low stays a read
        idle(); host_start_n = 0; ctrl_start_n = 0; addr = 6'h21; all_wr_n = 0;
        wdata = 32'hDEADBEEF; run("R4");
        step(1'b0, 1'b0, "R4");

        // R3 host strobe ignored while first enable high: acts as continue
        idle(); host_start_n = 0; en_lo_a_n = 1; step_n = 0; addr = 6'h3F; run("R3");
        step(1'b0, 1'b0, "R3");

        // R1 strobe with bad enables deselects; R2 deselect persists
        idle(); ctrl_start_n = 0; en_hi = 0; addr = 6'h30; run("R1");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, "R2");
        begin_ctrl(6'h30, 1'b0, "R2");
        step(1'b1, 1'b0, "R2");

        // R9 output enable acts without a clock edge
        idle(); read_oe_n = 1; run("R9");
        idle(); read_oe_n = 0; run("R9");

        // R10 write attempts during sleep and recovery edge are ignored
        idle(); nap = 1; all_wr_n = 0; step_n = 0; wdata = 32'h0BADF00D; run("R10");
        idle(); nap = 1; all_wr_n = 0; run("R10");
        idle(); all_wr_n = 0; step_n = 0; wdata = 32'h0BADF00D; run("R10");
        step(1'b0, 1'b0, "R10");
        step(1'b1, 1'b0, "R10");

        // Constrained random, both burst orders
        for (int m = 0; m < 2; m++) begin
            wrap_linear = (m == 0);
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 100) < 88) begin
                    en_lo_a_n = 0; en_hi = 1; en_lo_b_n = 0;
                end else begin
                    en_lo_a_n = $urandom; en_hi = $urandom; en_lo_b_n = $urandom;
                end
                host_start_n = ($urandom % 100) >= 10;
                ctrl_start_n = ($urandom % 100) >= 18;
                step_n = ($urandom % 100) >= 65;
                all_wr_n = ($urandom % 100) >= 15;
                lane_wr_en_n = ($urandom % 100) >= 35;
                lane_sel_n = $urandom;
                read_oe_n = ($urandom % 100) < 10;
                nap = ($urandom % 100) < 4;
                addr = $urandom;
                wdata = $urandom;
                run("R8");
            end
        end

        // Final sweep read of whole array (R8)
        idle();
        for (int b = 0; b < DEPTH / 4; b++) begin
            begin_ctrl(AW'(b * 4), 1'b0, "R8");
            for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R8");
        end
        step(1'b0, 1'b0, "R8");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule